// File: doc/BRIEF.md
# Shadow Memory Region Attribute Decoder

This block keeps the shadow-control state of a PC-style chipset and turns it into per-access routing attributes for the upper memory window from 0xC0000 to 0xFFFFF. Software reaches the control state through two I/O ports. It writes a register number to the index port, then reads or writes that register through the data port. For every memory address that the block is given, it reports two results at once. The first says whether a read is served by internal (shadow) memory or by the external bus. The second says whether a write goes to internal memory, goes to the external bus, or is dropped.

The window is split into four 64 KB segments. The C, D and E segments each have a segment enable, a write-protect bit, and four enables for their 16 KB blocks. These bits sit in different control bytes. The F segment has its own scheme. In normal mode it reads from shadow memory and writes there only when a write-enable bit permits it. In copy mode it reads from the external bus and writes into shadow memory, so that a ROM can be copied into the shadow RAM. The decode is purely combinational from the address and the stored control state.

Top module: `shd_region_decoder`

## Requirements
- R1: A write to I/O address 0x22 loads the register index. A write to I/O address 0x24 stores into the indexed register. `io_rdata` shows the indexed register whenever `io_addr` is 0x24.
- R2: Whenever `io_addr` is anything other than 0x24, `io_rdata` is 0xFF.
- R3: After reset, register 0x10 reads 0x3F, register 0x11 reads 0xF0, and registers 0x12, 0x13 and 0x14 read 0x00.
- R4: Registers 0x10 through 0x14 keep all eight written bits. A data write to any other index is ignored, and that index always reads 0x00.
- R5: F segment (address bits 19:16 = 0xF), when bit 7 of register 0x11 is 1: reads go external (`rd_int`=0) and writes go internal (`wr_route`=01).
- R6: F segment, when bit 7 of register 0x11 is 0: reads go internal. Writes go internal (01) if bit 7 of register 0x14 is 1, and are blocked (10) otherwise.
- R7: C segment (bits 19:16 = 0xC): the segment enable is bit 4 of register 0x11. Block k (address bits 15:14 = k) is enabled by bit 4+k of register 0x13. Bit 0 of register 0x11 is the write-protect bit.
- R8: D segment (0xD): the segment enable is bit 5 of register 0x11. Block k is enabled by bit k of register 0x12. Bit 1 of register 0x11 is the write-protect bit.
- R9: E segment (0xE): the segment enable is bit 6 of register 0x11. Block k is enabled by bit 4+k of register 0x12. Bit 2 of register 0x11 is the write-protect bit.
- R10: In the C, D and E segments, a block whose segment enable and block enable are both 1 reads internal. Its writes go internal (01), or are blocked (10) when the segment's write-protect bit is 1. Any other block routes reads external and writes external (00).
- R11: Any address below 0xC0000 routes reads external and writes external, whatever the control state.
- R12: `rd_int` is 1 for internal and 0 for external. `wr_route` uses 00 for external, 01 for internal and 10 for blocked, and it never shows 11.
- R13: Register 0x10 has no effect on routing. A change of register 0x11 to 0x14 shows in the routing outputs in the first cycle after the clock edge that takes the data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, sampled on the rising clock edge |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_addr | input | 20 | Memory address to classify |
| rd_int | output | 1 | 1: reads served internally; 0: external bus |
| wr_route | output | 2 | 00 external, 01 internal, 10 blocked |

## Verification
The routing outputs and `io_rdata` are combinational, so both are due in the same cycle as the address that produces them. A data-port write changes the routing and the read-back from the cycle after the edge that samples it. The driver changes inputs on the falling edge and queues the result it expects. The monitor compares the outputs 1 ns after that same falling edge, so every comparison falls well clear of the rising edge. Each control write is held for one full cycle before the routing is probed, which checks that the first post-write cycle already shows the new attributes.

// File: rtl/shd_pkg.sv
package shd_pkg;

  typedef enum logic [1:0] {
    WR_EXT = 2'b00,
    WR_INT = 2'b01,
    WR_BLK = 2'b10
  } wr_route_e;

  typedef struct packed {
    logic      rd_int;
    wr_route_e wr;
  } route_t;

  localparam route_t ROUTE_EXT = '{rd_int: 1'b0, wr: WR_EXT};

  // Segment numbering inside the upper window: 0=C, 1=D, 2=E, 3=F
  localparam int NUM_BLK_SEGS = 3;

  // Segment enable bits in the main control byte: C=4, D=5, E=6
  function automatic int seg_en_bit(input int s);
    return 4 + s;
  endfunction

  // Write-protect bits in the main control byte: C=0, D=1, E=2
  function automatic int seg_wp_bit(input int s);
    return s;
  endfunction

  // Low bit of the block-enable nibble: C uses high nibble, D low, E high
  function automatic int seg_blk_lsb(input int s);
    return (s == 1) ? 0 : 4;
  endfunction

  // Which byte carries the block enables: 1 = C byte, 0 = shared D/E byte
  function automatic bit seg_uses_c_byte(input int s);
    return (s == 0);
  endfunction

endpackage

// File: rtl/shd_regfile.sv
module shd_regfile #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0024,
  parameter int          FIRST_IDX = 'h10,
  parameter int          NUM_REGS  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_wr,
  input  logic [ADDR_W-1:0]             io_addr,
  input  logic [DATA_W-1:0]             io_wdata,
  output logic [DATA_W-1:0]             io_rdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

  localparam int LAST_IDX = FIRST_IDX + NUM_REGS - 1;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  function automatic logic [DATA_W-1:0] reset_val(input int i);
    case (i)
      0:       return DATA_W'('h3F);
      1:       return DATA_W'('hF0);
      default: return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] index_q, index_d;
  logic              index_en;
  logic              data_sel, idx_sel, in_range;
  logic [NUM_REGS-1:0] reg_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_d;

  assign idx_sel  = (io_addr == ADDR_W'(IDX_PORT));
  assign data_sel = (io_addr == ADDR_W'(DATA_PORT));
  assign in_range = (int'(index_q) >= FIRST_IDX) && (int'(index_q) <= LAST_IDX);

  // next state
  always_comb begin
    index_en = io_wr && idx_sel;
    index_d  = io_wdata;
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_comb begin
        reg_en[g] = io_wr && data_sel && (int'(index_q) == FIRST_IDX + g);
        regs_d[g] = io_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         regs_q[g] <= reset_val(g);
        else if (reg_en[g]) regs_q[g] <= regs_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        index_q <= '0;
    else if (index_en) index_q <= index_d;
  end

  // read path
  always_comb begin
    io_rdata = ALL_ONES;
    if (data_sel) begin
      io_rdata = '0;
      if (in_range) begin
        for (int i = 0; i < NUM_REGS; i++)
          if (int'(index_q) == FIRST_IDX + i) io_rdata = regs_q[i];
      end
    end
  end

endmodule

// File: rtl/shd_seg_route.sv
module shd_seg_route
  import shd_pkg::*;
#(
  parameter int EN_BIT  = 4,
  parameter int WP_BIT  = 0,
  parameter int BLK_LSB = 4,
  parameter int BLK_W   = 2
) (
  input  logic [7:0]       ctl,
  input  logic [7:0]       blk_en,
  input  logic [BLK_W-1:0] blk_sel,
  output route_t           route
);

  localparam int NUM_BLK = 1 << BLK_W;

  logic [NUM_BLK-1:0] nib;
  logic               hit;

  assign nib = blk_en[BLK_LSB +: NUM_BLK];
  assign hit = ctl[EN_BIT] && nib[blk_sel];

  always_comb begin
    route = ROUTE_EXT;
    if (hit) begin
      route.rd_int = 1'b1;
      route.wr     = ctl[WP_BIT] ? WR_BLK : WR_INT;
    end
  end

endmodule

// File: rtl/shd_attr_mux.sv
module shd_attr_mux
  import shd_pkg::*;
#(
  parameter int MEM_AW = 20
) (
  input  logic [MEM_AW-1:0]            mem_addr,
  input  logic [7:0]                   ctl,
  input  logic [7:0]                   fctl,
  input  route_t [NUM_BLK_SEGS-1:0]    seg_route,
  output logic                         rd_int,
  output logic [1:0]                   wr_route
);

  localparam int SEG_LSB = MEM_AW - 4;

  logic       upper;
  logic [1:0] seg;
  route_t     f_route, sel;

  assign upper = &mem_addr[MEM_AW-1 -: 2];
  assign seg   = mem_addr[SEG_LSB +: 2];

  always_comb begin
    if (ctl[7]) begin
      f_route.rd_int = 1'b0;
      f_route.wr     = WR_INT;
    end else begin
      f_route.rd_int = 1'b1;
      f_route.wr     = fctl[7] ? WR_INT : WR_BLK;
    end
  end

  always_comb begin
    sel = ROUTE_EXT;
    if (upper) begin
      if (seg == 2'd3) sel = f_route;
      else             sel = seg_route[seg];
    end
  end

  assign rd_int   = sel.rd_int;
  assign wr_route = sel.wr;

endmodule

// File: rtl/shd_region_decoder.sv
module shd_region_decoder
  import shd_pkg::*;
#(
  parameter int IO_AW  = 16,
  parameter int MEM_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  output logic              rd_int,
  output logic [1:0]        wr_route
);

  localparam int NUM_REGS = 5;
  localparam int BLK_LSB  = MEM_AW - 6;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_REGS-1:0][7:0] regs;

  shd_regfile #(
    .ADDR_W   (IO_AW),
    .DATA_W   (8),
    .IDX_PORT (16'h0022),
    .DATA_PORT(16'h0024),
    .FIRST_IDX('h10),
    .NUM_REGS (NUM_REGS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .regs_q  (regs)
  );

  // regs[1] main control, regs[2] D/E block enables, regs[3] C block enables,
  // regs[4] F write enable; regs[0] is storage only
  route_t [NUM_BLK_SEGS-1:0] seg_route;

  generate
    for (genvar s = 0; s < NUM_BLK_SEGS; s++) begin : g_seg
      shd_seg_route #(
        .EN_BIT (seg_en_bit(s)),
        .WP_BIT (seg_wp_bit(s)),
        .BLK_LSB(seg_blk_lsb(s)),
        .BLK_W  (2)
      ) u_seg (
        .ctl    (regs[1]),
        .blk_en (seg_uses_c_byte(s) ? regs[3] : regs[2]),
        .blk_sel(mem_addr[BLK_LSB +: 2]),
        .route  (seg_route[s])
      );
    end
  endgenerate

  shd_attr_mux #(.MEM_AW(MEM_AW)) u_mux (
    .mem_addr (mem_addr),
    .ctl      (regs[1]),
    .fctl     (regs[4]),
    .seg_route(seg_route),
    .rd_int   (rd_int),
    .wr_route (wr_route)
  );

endmodule

// File: rtl/shd_region_decoder_chk.sv
module shd_region_decoder_chk #(
  parameter int IO_AW  = 16,
  parameter int MEM_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IO_AW-1:0]  io_addr,
  input logic [7:0]        io_rdata,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              rd_int,
  input logic [1:0]        wr_route
);

  logic in_f, in_upper;
  assign in_upper = &mem_addr[MEM_AW-1 -: 2];
  assign in_f     = &mem_addr[MEM_AW-1 -: 4];

  AST_OTHER_PORT_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != IO_AW'(16'h0024)) |-> (io_rdata == 8'hFF)); // R2

  AST_LOW_WINDOW_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_upper |-> (!rd_int && wr_route == 2'b00)); // R11

  AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_route != 2'b11); // R12

  AST_BLOCKED_READS_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_route == 2'b10) |-> rd_int); // R10

  AST_F_COPY_WRITES_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_f && !rd_int) |-> (wr_route == 2'b01)); // R5

  AST_F_NORMAL_NEVER_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_f && rd_int) |-> (wr_route != 2'b00)); // R6

endmodule

bind shd_region_decoder shd_region_decoder_chk #(.IO_AW(IO_AW), .MEM_AW(MEM_AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_addr (io_addr),
  .io_rdata(io_rdata),
  .mem_addr(mem_addr),
  .rd_int  (rd_int),
  .wr_route(wr_route)
);

// File: tb/shd_region_decoder_tb_top.sv
`timescale 1ns/1ps
module shd_region_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr;
  logic        rd_int;
  logic [1:0]  wr_route;

  always #2 clk = ~clk; // 250 MHz

  shd_region_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .rd_int(rd_int), .wr_route(wr_route)
  );

  typedef struct {
    bit         is_route;
    string      req;
    logic       exp_rd;
    logic [1:0] exp_wr;
    logic [7:0] exp_data;
  } item_t;

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 0;

  // reference state built from the requirements
  logic [7:0] m_idx;
  logic [7:0] m_reg [0:4];

  task automatic model_reset();
    m_idx = 8'h00;
    m_reg[0] = 8'h3F; m_reg[1] = 8'hF0;
    m_reg[2] = 8'h00; m_reg[3] = 8'h00; m_reg[4] = 8'h00;
  endtask

  task automatic exp_route(input logic [19:0] a, output logic rd, output logic [1:0] wr);
    logic [1:0] seg, b;
    logic en, be, wp;
    rd = 1'b0; wr = 2'b00;
    seg = a[17:16]; b = a[15:14];
    if (a[19:18] == 2'b11) begin
      if (seg == 2'd3) begin
        if (m_reg[1][7]) begin rd = 1'b0; wr = 2'b01; end
        else begin rd = 1'b1; wr = m_reg[4][7] ? 2'b01 : 2'b10; end
      end else begin
        case (seg)
          2'd0:    begin en = m_reg[1][4]; be = m_reg[3][4+b]; wp = m_reg[1][0]; end
          2'd1:    begin en = m_reg[1][5]; be = m_reg[2][b];   wp = m_reg[1][1]; end
          default: begin en = m_reg[1][6]; be = m_reg[2][4+b]; wp = m_reg[1][2]; end
        endcase
        if (en && be) begin rd = 1'b1; wr = wp ? 2'b10 : 2'b01; end
      end
    end
  endtask

  // driver tasks: inputs change on the falling edge
  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    if (a == 16'h0022) m_idx = d;
    else if (a == 16'h0024 && m_idx >= 8'h10 && m_idx <= 8'h14) m_reg[m_idx - 8'h10] = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
    io_write(16'h0022, idx);
    io_write(16'h0024, d);
  endtask

  task automatic chk_read(input logic [15:0] a, input logic [7:0] expv, input string req);
    item_t it;
    @(negedge clk);
    io_addr = a;
    it.is_route = 0; it.req = req; it.exp_data = expv; it.exp_rd = 0; it.exp_wr = 0;
    sb_q.push_back(it);
  endtask

  task automatic chk_reg(input logic [7:0] idx, input logic [7:0] expv, input string req);
    io_write(16'h0022, idx);
    chk_read(16'h0024, expv, req);
  endtask

  task automatic chk_route(input logic [19:0] a, input string req);
    item_t it;
    @(negedge clk);
    mem_addr = a;
    it.is_route = 1; it.req = req; it.exp_data = 0;
    exp_route(a, it.exp_rd, it.exp_wr);
    sb_q.push_back(it);
  endtask

  task automatic chk_route_lit(input logic [19:0] a, input logic rd, input logic [1:0] wr,
                               input string req);
    item_t it;
    @(negedge clk);
    mem_addr = a;
    it.is_route = 1; it.req = req; it.exp_data = 0; it.exp_rd = rd; it.exp_wr = wr;
    sb_q.push_back(it);
  endtask

  // monitor: compares 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (it.is_route) begin
          if (rd_int !== it.exp_rd || wr_route !== it.exp_wr) begin
            n_bad++;
            $display("FAIL %s addr=%05h rd_int=%0b/%0b wr_route=%02b/%02b (actual/expected)",
                     it.req, mem_addr, rd_int, it.exp_rd, wr_route, it.exp_wr);
          end
        end else if (io_rdata !== it.exp_data) begin
          n_bad++;
          $display("FAIL %s io_addr=%04h io_rdata=%02h expected=%02h",
                   it.req, io_addr, io_rdata, it.exp_data);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    io_wr = 0; io_addr = 16'h0000; io_wdata = 0; mem_addr = 20'h00000;
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset values
    chk_reg(8'h10, 8'h3F, "R3");
    chk_reg(8'h11, 8'hF0, "R3");
    chk_reg(8'h12, 8'h00, "R3");
    chk_reg(8'h13, 8'h00, "R3");
    chk_reg(8'h14, 8'h00, "R3");
    // R5 copy mode after reset, R10 disabled blocks
    chk_route_lit(20'hF1234, 1'b0, 2'b01, "R5");
    chk_route_lit(20'hC4000, 1'b0, 2'b00, "R10");

    // R2 other ports
    chk_read(16'h0022, 8'hFF, "R2");
    chk_read(16'h0023, 8'hFF, "R2");
    chk_read(16'h0000, 8'hFF, "R2");

    // R1 / R4 full byte storage
    set_reg(8'h10, 8'hA5);
    chk_read(16'h0024, 8'hA5, "R1");
    set_reg(8'h14, 8'h5A); chk_read(16'h0024, 8'h5A, "R4");
    chk_reg(8'h10, 8'hA5, "R4");
    // R4 unimplemented index ignored
    set_reg(8'h20, 8'hFF);
    chk_read(16'h0024, 8'h00, "R4");
    set_reg(8'h0F, 8'h77);
    chk_read(16'h0024, 8'h00, "R4");
    chk_reg(8'h10, 8'hA5, "R4");
    chk_reg(8'h14, 8'h5A, "R4");

    // R6 F normal mode, write blocked then enabled
    set_reg(8'h14, 8'h00);
    set_reg(8'h11, 8'h70);
    chk_route_lit(20'hFFFF0, 1'b1, 2'b10, "R6");
    set_reg(8'h14, 8'h80);
    chk_route_lit(20'hF0000, 1'b1, 2'b01, "R13");
    set_reg(8'h11, 8'hF0);
    chk_route_lit(20'hF8000, 1'b0, 2'b01, "R5");

    // R7 C segment blocks
    set_reg(8'h13, 8'hA0);
    for (int k = 0; k < 4; k++) chk_route(20'hC0000 | (k << 14), "R7");
    set_reg(8'h11, 8'hF1);
    for (int k = 0; k < 4; k++) chk_route(20'hC0123 | (k << 14), "R7");

    // R8 / R9 D and E segments
    set_reg(8'h12, 8'h6C);
    for (int k = 0; k < 4; k++) chk_route(20'hD0000 | (k << 14), "R8");
    for (int k = 0; k < 4; k++) chk_route(20'hE2000 | (k << 14), "R9");
    set_reg(8'h11, 8'hF6);
    for (int k = 0; k < 4; k++) chk_route(20'hD3FFF | (k << 14), "R8");
    for (int k = 0; k < 4; k++) chk_route(20'hE0010 | (k << 14), "R9");

    // R10 segment disables override block enables
    set_reg(8'h11, 8'h80);
    chk_route_lit(20'hC8000, 1'b0, 2'b00, "R10");
    chk_route_lit(20'hD8000, 1'b0, 2'b00, "R10");
    chk_route_lit(20'hE4000, 1'b0, 2'b00, "R10");

    // R11 below the window with everything enabled
    set_reg(8'h11, 8'h70); set_reg(8'h12, 8'hFF); set_reg(8'h13, 8'hFF);
    chk_route_lit(20'hBFFFF, 1'b0, 2'b00, "R11");
    chk_route_lit(20'h00000, 1'b0, 2'b00, "R11");
    chk_route_lit(20'h80000, 1'b0, 2'b00, "R11");
    chk_route_lit(20'hC0000, 1'b1, 2'b01, "R12");

    // R13 register 0x10 has no routing effect
    set_reg(8'h10, 8'h00);
    chk_route_lit(20'hD0000, 1'b1, 2'b01, "R13");
    chk_route_lit(20'hF0000, 1'b1, 2'b01, "R13");
    set_reg(8'h10, 8'hFF);
    chk_route_lit(20'hE0000, 1'b1, 2'b01, "R13");

    // sweep every 16 KB block in the window
    for (int k = 0; k < 16; k++) chk_route(20'hC0000 + (k << 14), "R12");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule